// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between a processor write bus and the program and pattern memories of a cartridge-style memory system. It turns the bank numbers written by the processor into the physical bank indices for each window. Processor writes in the upper half of the address space go to a select register and eight bank registers. The register layout uses four 8 KB program windows and eight 1 KB pattern windows.

Two mode bits in the select register choose where the program and pattern banks land. A separate write port in the low address area loads an extra high bank bit for each 4 KB half of the pattern space. Reads of that area always return a fixed value. The block also keeps the nametable mirroring choice, which a four-screen strap can freeze.

The write interface is a plain one-cycle strobe with no back-pressure: every strobed write is taken in the same cycle. All window outputs are combinational decodes of register state, so they carry no handshake.

Top module: `bank_mapper_top`

## Requirements
- R1: The upper-area register is chosen from address bits 15, 14, 13 and 0 only. An upper-area write is one with bit 15 set. With bits 14 and 13 clear, bit 0 = 0 is the select register and bit 0 = 1 is the bank data port. With bit 14 clear, bit 13 set and bit 0 = 0, the write goes to the mirroring register. Every other upper-area combination, and any write below 0x8000 outside the low extension range, changes nothing.
- R2: Bits 2:0 of the select register name the bank register that a bank-data write updates. Targets 0 and 1 are 2 KB pattern banks, targets 2 to 5 are 1 KB pattern banks, and targets 6 and 7 are program banks A and B.
- R3: A write to target 0 or 1 stores the data with bit 0 cleared. The first 1 KB window of that pair gets the stored value, and the second gets the stored value plus one.
- R4: With select bit 6 clear, program windows 0 to 3 hold A, B, N-2 and N-1. With bit 6 set, they hold N-2, B, A and N-1, where N is the PRG_BANKS parameter.
- R5: Program window 3 always holds N-1, in both layouts.
- R6: With select bit 7 clear, pattern windows 0 to 3 come from targets 0 and 1 as the pairs (t0, t0+1, t1, t1+1), and windows 4 to 7 come from targets 2 to 5. With bit 7 set, the two halves trade places.
- R7: A write to an address strictly greater than 0x4100 and strictly less than 0x6000 loads two extension bits. Data bit 0 becomes bit 8 of the bank number for pattern windows 0 to 3, and data bit 4 becomes bit 8 for windows 4 to 7. Writes to 0x4100 and to 0x6000 are ignored.
- R8: A read address from 0x4100 to 0x5FFF inclusive sets rd_hit_o and returns 0x01. Any other read address returns 0x00 with rd_hit_o clear.
- R9: A mirroring-register write sets mirror_h_o to data bit 0 (1 = horizontal, 0 = vertical), unless four_screen_i is high, in which case mirror_h_o keeps its value.
- R10: While reset is held, and right after it: program banks A = 0 and B = 1; pattern targets 0 to 5 = 0, 2, 4, 5, 6, 7; select = 0; both extension bits = 0; mirror_h_o = 0.
- R11: A write sampled at a rising clock edge shows on the window outputs after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 16 | Read address for the low-area readback |
| four_screen_i | input | 1 | Strap: freezes mirroring when high |
| rd_data_o | output | 8 | Low-area read data |
| rd_hit_o | output | 1 | Read address lies in the low area |
| prg_win_o | output | 4*PRG_BW | Program bank for window i at bits [i*PRG_BW +: PRG_BW] |
| chr_win_o | output | 72 | Pattern bank (9 bits) for window i at bits [i*9 +: 9] |
| mirror_h_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench walks a write sequence through every bank target. A design that forgot to clear bit 0 on the 2 KB targets, or that misplaced the +1 window, would show an odd value in the wrong 1 KB slot. It probes the exclusive edges of the low extension range at 0x4100 and 0x6000, where an inclusive compare would wrongly set bit 8. It uses aliased addresses such as 0x9FFE and 0x8FF3 and ignored ones such as 0xC001, which catch a decoder that reads too many or too few address bits. It also flips both layout bits and checks the four-screen freeze, because swapping the wrong halves, or letting bit 6 move window 3, changes which bank appears where.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int DATA_W = 8;
  localparam int CHR_W  = DATA_W + 1;
  localparam int NUM_TARGETS = 8;
  localparam int NUM_CHR_REGS = 6;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [CHR_W-1:0]  chr_bank_t;

  // upper-area register kind, indexed by {addr[14], addr[13], addr[0]}
  typedef enum logic [2:0] {
    UREG_SELECT = 3'b000,
    UREG_BANK   = 3'b001,
    UREG_MIRROR = 3'b010
  } ureg_e;

  function automatic byte_t chr_reset_value(input int idx);
    return (idx < 2) ? byte_t'(2 * idx) : byte_t'(idx + 2);
  endfunction
endpackage

// File: rtl/bank_regfile.sv
module bank_regfile
  import mapper_pkg::*;
#(
  parameter int PRG_BW = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [15:0]              wr_addr_i,
  input  byte_t                    wr_data_i,
  input  logic                     four_screen_i,
  output logic [NUM_CHR_REGS-1:0][DATA_W-1:0] chr_regs_o,
  output logic [PRG_BW-1:0]        prg_a_o,
  output logic [PRG_BW-1:0]        prg_b_o,
  output logic                     prg_swap_o,
  output logic                     chr_invert_o,
  output logic                     hi_lo_o,
  output logic                     hi_up_o,
  output logic                     mirror_h_o
);
  byte_t                 sel_q;
  logic [PRG_BW-1:0]     prg_a_q, prg_b_q;
  logic                  hi_lo_q, hi_up_q, mirror_q;
  logic [2:0]            ureg;
  logic                  up_wr, lo_wr, bank_wr, sel_wr, mir_wr;

  assign ureg    = {wr_addr_i[14], wr_addr_i[13], wr_addr_i[0]};
  assign up_wr   = wr_en_i && wr_addr_i[15];
  assign sel_wr  = up_wr && (ureg == UREG_SELECT);
  assign bank_wr = up_wr && (ureg == UREG_BANK);
  assign mir_wr  = up_wr && (ureg == UREG_MIRROR) && !four_screen_i;
  assign lo_wr   = wr_en_i && (wr_addr_i > 16'h4100) && (wr_addr_i < 16'h6000);

  // pattern bank registers, one per target 0..5
  for (genvar g = 0; g < NUM_CHR_REGS; g++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chr_regs_o[g] <= chr_reset_value(g);
      end else if (bank_wr && (sel_q[2:0] == 3'(g))) begin
        if (g < 2) chr_regs_o[g] <= {wr_data_i[DATA_W-1:1], 1'b0};
        else       chr_regs_o[g] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      prg_a_q  <= PRG_BW'(0);
      prg_b_q  <= PRG_BW'(1);
      hi_lo_q  <= 1'b0;
      hi_up_q  <= 1'b0;
      mirror_q <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= wr_data_i;
      if (bank_wr && sel_q[2:0] == 3'd6) prg_a_q <= wr_data_i[PRG_BW-1:0];
      if (bank_wr && sel_q[2:0] == 3'd7) prg_b_q <= wr_data_i[PRG_BW-1:0];
      if (mir_wr) mirror_q <= wr_data_i[0];
      if (lo_wr) begin
        hi_lo_q <= wr_data_i[0];
        hi_up_q <= wr_data_i[4];
      end
    end
  end

  assign prg_a_o      = prg_a_q;
  assign prg_b_o      = prg_b_q;
  assign prg_swap_o   = sel_q[6];
  assign chr_invert_o = sel_q[7];
  assign hi_lo_o      = hi_lo_q;
  assign hi_up_o      = hi_up_q;
  assign mirror_h_o   = mirror_q;

  // select register takes the written byte
  p_select_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i[15] && wr_addr_i[14:13] == 2'b00 && !wr_addr_i[0])
      |=> ({chr_invert_o, prg_swap_o} == $past(wr_data_i[7:6])));

  // 2 KB target stores an even value
  p_even_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && sel_q[2:0] == 3'd0) |=> (chr_regs_o[0] == {$past(wr_data_i[7:1]), 1'b0}));

  // four-screen strap freezes mirroring
  p_mirror_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && four_screen_i) |=> $stable(mirror_h_o));

  // extension bits follow a low-range write
  p_ext_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i > 16'h4100 && wr_addr_i < 16'h6000)
      |=> (hi_lo_o == $past(wr_data_i[0]) && hi_up_o == $past(wr_data_i[4])));

  // undecoded upper-area writes touch no bank state
  p_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i[15] && (wr_addr_i[14] || (wr_addr_i[13] && wr_addr_i[0])))
      |=> ($stable(chr_regs_o) && $stable(prg_a_o) && $stable(prg_b_o)
           && $stable(prg_swap_o) && $stable(chr_invert_o)));
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map #(
  parameter int PRG_BANKS = 32,
  parameter int PRG_BW    = $clog2(PRG_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PRG_BW-1:0]      prg_a_i,
  input  logic [PRG_BW-1:0]      prg_b_i,
  input  logic                   swap_i,
  output logic [3:0][PRG_BW-1:0] win_o
);
  localparam logic [PRG_BW-1:0] LAST_BANK   = PRG_BW'(PRG_BANKS - 1);
  localparam logic [PRG_BW-1:0] SECOND_LAST = PRG_BW'(PRG_BANKS - 2);

  always_comb begin
    win_o[1] = prg_b_i;
    win_o[3] = LAST_BANK;
    if (swap_i) begin
      win_o[0] = SECOND_LAST;
      win_o[2] = prg_a_i;
    end else begin
      win_o[0] = prg_a_i;
      win_o[2] = SECOND_LAST;
    end
  end

  // the bank A window moves between slots 0 and 2 when the layout bit toggles
  p_swap_moves_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(swap_i) && $stable(prg_a_i)) |-> (win_o[0] == $past(win_o[2])));
endmodule

// File: rtl/chr_window_map.sv
module chr_window_map
  import mapper_pkg::*;
(
  input  logic [NUM_CHR_REGS-1:0][DATA_W-1:0] chr_regs_i,
  input  logic                                invert_i,
  input  logic                                hi_lo_i,
  input  logic                                hi_up_i,
  output logic [7:0][CHR_W-1:0]               win_o
);
  logic [3:0][DATA_W-1:0] pair_half;   // windows from the two 2 KB targets
  logic [3:0][DATA_W-1:0] single_half; // windows from the four 1 KB targets

  for (genvar p = 0; p < 2; p++) begin : g_pair
    assign pair_half[2*p]   = chr_regs_i[p];
    assign pair_half[2*p+1] = chr_regs_i[p] | DATA_W'(1);
  end

  for (genvar s = 0; s < 4; s++) begin : g_single
    assign single_half[s] = chr_regs_i[s+2];
  end

  for (genvar w = 0; w < 4; w++) begin : g_win
    assign win_o[w]   = {hi_lo_i, invert_i ? single_half[w] : pair_half[w]};
    assign win_o[w+4] = {hi_up_i, invert_i ? pair_half[w] : single_half[w]};
  end
endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int PRG_BW    = $clog2(PRG_BANKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [15:0]           wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [15:0]           rd_addr_i,
  input  logic                  four_screen_i,
  output logic [7:0]            rd_data_o,
  output logic                  rd_hit_o,
  output logic [4*PRG_BW-1:0]   prg_win_o,
  output logic [8*CHR_W-1:0]    chr_win_o,
  output logic                  mirror_h_o
);
  localparam logic [15:0] LOW_FIRST = 16'h4100;
  localparam logic [15:0] LOW_LAST  = 16'h5FFF;
  localparam byte_t       LOW_VALUE = 8'h01;

  logic [NUM_CHR_REGS-1:0][DATA_W-1:0] chr_regs;
  logic [PRG_BW-1:0]      prg_a, prg_b;
  logic                   prg_swap, chr_invert, hi_lo, hi_up;
  logic [3:0][PRG_BW-1:0] prg_win;
  logic [7:0][CHR_W-1:0]  chr_win;

  bank_regfile #(.PRG_BW(PRG_BW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .four_screen_i (four_screen_i),
    .chr_regs_o    (chr_regs),
    .prg_a_o       (prg_a),
    .prg_b_o       (prg_b),
    .prg_swap_o    (prg_swap),
    .chr_invert_o  (chr_invert),
    .hi_lo_o       (hi_lo),
    .hi_up_o       (hi_up),
    .mirror_h_o    (mirror_h_o)
  );

  prg_window_map #(.PRG_BANKS(PRG_BANKS), .PRG_BW(PRG_BW)) u_prg (
    .clk     (clk),
    .rst_n   (rst_n),
    .prg_a_i (prg_a),
    .prg_b_i (prg_b),
    .swap_i  (prg_swap),
    .win_o   (prg_win)
  );

  chr_window_map u_chr (
    .chr_regs_i (chr_regs),
    .invert_i   (chr_invert),
    .hi_lo_i    (hi_lo),
    .hi_up_i    (hi_up),
    .win_o      (chr_win)
  );

  assign prg_win_o = prg_win;
  assign chr_win_o = chr_win;

  always_comb begin
    rd_hit_o  = (rd_addr_i >= LOW_FIRST) && (rd_addr_i <= LOW_LAST);
    rd_data_o = rd_hit_o ? LOW_VALUE : 8'h00;
  end

  // the last program window never moves
  p_last_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(prg_win_o[3*PRG_BW +: PRG_BW]));

  // readback value is fixed
  p_low_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_o |-> (rd_data_o == LOW_VALUE));
endmodule

// File: tb/bank_mapper_top_bench.sv
module bank_mapper_top_bench;
  localparam int PRG_BANKS = 32;
  localparam int PRG_BW = 5;
  localparam int NV = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic        four_screen = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_hit;
  logic [4*PRG_BW-1:0] prg_win;
  logic [71:0] chr_win;
  logic        mirror_h;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_mapper_top #(.PRG_BANKS(PRG_BANKS)) u_bank_mapper_top (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .four_screen_i(four_screen),
    .rd_data_o(rd_data), .rd_hit_o(rd_hit), .prg_win_o(prg_win),
    .chr_win_o(chr_win), .mirror_h_o(mirror_h)
  );

  // {addr, data, window (0-7 pattern, 8-11 program, 12 mirror), expected}
  localparam logic [36:0] VEC [NV] = '{
    {16'h8000, 8'h00, 4'd8,  9'h000}, // R2 select target 0
    {16'h8001, 8'h13, 4'd0,  9'h012}, // R3 bit 0 cleared
    {16'h0000, 8'hFF, 4'd1,  9'h013}, // R3 +1, R1 ignored
    {16'h8000, 8'h01, 4'd8,  9'h000},
    {16'h8001, 8'h21, 4'd2,  9'h020}, // R3
    {16'h0000, 8'h00, 4'd3,  9'h021},
    {16'h8000, 8'h02, 4'd8,  9'h000},
    {16'h8001, 8'h40, 4'd4,  9'h040}, // R2
    {16'h8000, 8'h05, 4'd8,  9'h000},
    {16'h8001, 8'h77, 4'd7,  9'h077}, // R2
    {16'h8000, 8'h06, 4'd8,  9'h000},
    {16'h8001, 8'h09, 4'd8,  9'h009}, // R2 bank A
    {16'h8000, 8'h07, 4'd9,  9'h001},
    {16'h8001, 8'h0B, 4'd9,  9'h00B}, // R2 bank B
    {16'h8000, 8'h47, 4'd8,  9'h01E}, // R4 swapped
    {16'h0000, 8'h00, 4'd10, 9'h009}, // R4
    {16'h0000, 8'h00, 4'd11, 9'h01F}, // R5
    {16'h0000, 8'h00, 4'd9,  9'h00B}, // R4
    {16'h8000, 8'h87, 4'd0,  9'h040}, // R6 inverted
    {16'h0000, 8'h00, 4'd3,  9'h077}, // R6
    {16'h0000, 8'h00, 4'd4,  9'h012}, // R6
    {16'h0000, 8'h00, 4'd5,  9'h013}, // R6
    {16'h0000, 8'h00, 4'd7,  9'h021}, // R6
    {16'h0000, 8'h00, 4'd8,  9'h009}, // R4 plain again
    {16'h4101, 8'h01, 4'd0,  9'h140}, // R7 low half
    {16'h0000, 8'h00, 4'd4,  9'h012}, // R7
    {16'h5FFF, 8'h10, 4'd0,  9'h040}, // R7 upper half
    {16'h0000, 8'h00, 4'd4,  9'h112}, // R7
    {16'h4100, 8'h11, 4'd4,  9'h112}, // R7 edge ignored
    {16'h6000, 8'h01, 4'd0,  9'h040}, // R7 edge ignored
    {16'hC001, 8'hFF, 4'd4,  9'h112}, // R1 ignored
    {16'h9FFE, 8'h00, 4'd0,  9'h012}, // R1 alias of select
    {16'h0000, 8'h00, 4'd4,  9'h140}, // R1
    {16'h8FF3, 8'h31, 4'd0,  9'h030}, // R1 alias of bank port
    {16'h0000, 8'h00, 4'd1,  9'h031}, // R3
    {16'hA000, 8'h01, 4'd12, 9'h001}, // R9 horizontal
    {16'hA001, 8'h00, 4'd12, 9'h001}, // R1 ignored
    {16'hA000, 8'h00, 4'd12, 9'h000}, // R9 vertical
    {16'hA000, 8'h01, 4'd12, 9'h001}, // R9
    {16'hE000, 8'h00, 4'd12, 9'h001}  // R1 ignored
  };

  function automatic logic [8:0] window(input int w);
    if (w < 8)       return chr_win[w*9 +: 9];
    else if (w < 12) return 9'(prg_win[(w-8)*PRG_BW +: PRG_BW]);
    else             return {8'h00, mirror_h};
  endfunction

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic check_reset(input string req);
    chk(req, window(8), 9'd0);
    chk(req, window(9), 9'd1);
    chk(req, window(10), 9'd30);
    chk(req, window(11), 9'd31);
    for (int w = 0; w < 4; w++) chk(req, window(w), 9'(w));
    for (int w = 4; w < 8; w++) chk(req, window(w), 9'(w));
    chk(req, window(12), 9'd0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R10 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset("R10 after reset");

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][36:21], VEC[i][20:13]);
      chk($sformatf("vector %0d", i), window(int'(VEC[i][12:9])), VEC[i][8:0]);
    end

    // R9 four-screen freeze
    four_screen = 1'b1;
    do_write(16'hA000, 8'h00);
    chk("R9 freeze", window(12), 9'd1);
    four_screen = 1'b0;

    // R8 readback
    rd_addr = 16'h4100; #1;
    chk("R8 low edge", {rd_hit, rd_data}, 9'h101);
    rd_addr = 16'h5FFF; #1;
    chk("R8 high edge", {rd_hit, rd_data}, 9'h101);
    rd_addr = 16'h3FFF; #1;
    chk("R8 outside", {rd_hit, rd_data}, 9'h000);
    rd_addr = 16'h6000; #1;
    chk("R8 above", {rd_hit, rd_data}, 9'h000);

    // R11 timing: select target 2, then write and probe both sides of the edge
    do_write(16'h8000, 8'h02);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h8001; wr_data = 8'h5A;
    #2;
    chk("R11 before edge", window(4), 9'h140);
    @(posedge clk); #2;
    chk("R11 after edge", window(4), 9'h15A);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;

    // R10 reset again restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    check_reset("R10 re-reset");
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule